// File: doc/BRIEF.md
# Halving Fault Isolator

This controller narrows a failing unit down to a single partitionable section by splitting the region in half again and again. The unit is modelled as `N_SEC` sections, numbered 0 to `N_SEC-1`, where `N_SEC` is a power of two from 2 to 64. The controller never tests the unit itself. It drives an enable mask that says which sections are switched on, and it raises a request. An external tester answers each request with an acknowledge pulse and a pass/fail verdict.

A `start` pulse first asks for a test of the whole unit. If that test passes, the run ends at once and reports that no fault was found. If it fails, the controller holds a suspect region as a pair of indices, `lo` and `hi`. It then works through a series of halving steps.

In each halving step only the lower half of the region, sections `lo` to `mid` with `mid = (lo+hi)/2`, is enabled and tested. The upper half is disabled. When the tested half fails, it becomes the new region. When it passes, the disabled upper half becomes the new region; that half is kept as the suspect, not thrown away. After log2(`N_SEC`) steps the region holds a single section, and the controller reports that section's index.

Top module: `halving_isolator`

## Requirements
- R1: While `rst` is high and on the cycle after it, `test_req`, `busy`, `done` and `no_fault` are 0 and `test_mask` is all zeros.
- R2: A `start` pulse seen while idle or finished makes `test_req` and `busy` go high on the next cycle, with every bit of `test_mask` set (the whole-unit test).
- R3: If the whole-unit test is acknowledged with `test_fail`=0, then on the next cycle `done`=1, `no_fault`=1, `test_req`=0 and `fault_idx`=0.
- R4: During a halving step, bit k of `test_mask` is 1 exactly when `lo` <= k <= (`lo`+`hi`)/2. Whenever `test_req` is 0, `test_mask` is all zeros.
- R5: A halving step acknowledged with `test_fail`=1 makes the tested lower half the new region, so `hi` becomes the old midpoint.
- R6: A halving step acknowledged with `test_fail`=0 makes the disabled upper half the new region, so `lo` becomes the old midpoint plus one.
- R7: A failing whole-unit test is followed by exactly log2(`N_SEC`) acknowledged halving steps. The controller then raises `done` with `no_fault`=0 and `fault_idx` equal to the isolated section.
- R8: `test_ack` is ignored while `test_req` is 0, and `start` is ignored while `busy` is 1.
- R9: The verdict is taken only in a cycle where `test_req` and `test_ack` are both 1. While a request waits for its acknowledge, `test_mask` stays stable and changes on `test_fail` have no effect.
- R10: After a run ends, `done`, `no_fault` and `fault_idx` hold until the next accepted `start`, and that `start` begins a fresh run over the whole range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; the whole-unit test is requested first |
| test_req | output | 1 | A test of the sections in `test_mask` is requested |
| test_mask | output | N_SEC | Enable mask; bit k set means section k is powered for the test |
| test_ack | input | 1 | The tester has finished the requested test |
| test_fail | input | 1 | Verdict, valid with `test_ack`: 1 = fail, 0 = pass |
| busy | output | 1 | A run is in progress |
| done | output | 1 | A run has ended; the result fields are valid |
| no_fault | output | 1 | With `done`: the whole-unit test passed |
| fault_idx | output | $clog2(N_SEC) | With `done` and not `no_fault`: the isolated section |

## Verification
The bench places a simulated fault at every section index in turn. This covers fault sites in the lowest section, in the highest section, and on both sides of every midpoint. As a result, every mix of pass and fail verdicts along the halving path occurs, and pass-driven narrowing is told apart from fail-driven narrowing.

Some runs use a fault-free unit, which separates the early no-fault exit from a full isolation. Acknowledge latency varies between runs, and `test_fail` toggles while the controller waits. These runs show that only acknowledged verdicts count.

Further runs pulse `start` mid-run, send stray acknowledges while idle, and issue back-to-back restarts. These show that the ignored inputs leave the region untouched and that each run begins again from the full range.

// File: rtl/halving_iso_pkg.sv
package halving_iso_pkg;

    // Largest section count the index fields can describe.
    localparam int MAX_SECTIONS = 64;
    localparam int SEC_IW       = $clog2(MAX_SECTIONS);

    typedef logic [SEC_IW-1:0] sec_idx_t;

    // Run phases of the controller.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WHOLE = 2'd1,
        PH_HALVE = 2'd2,
        PH_FINAL = 2'd3
    } phase_e;

    // Suspect region, inclusive bounds.
    typedef struct packed {
        sec_idx_t lo;
        sec_idx_t hi;
    } region_t;

    // Midpoint of the region; the sum carries one extra bit.
    function automatic sec_idx_t split_point(region_t r);
        logic [SEC_IW:0] sum;
        sum = {1'b0, r.lo} + {1'b0, r.hi};
        return sum[SEC_IW:1];
    endfunction

    // Region covering every section of an n-section unit.
    function automatic region_t full_region(int unsigned n);
        region_t r;
        r.lo = '0;
        r.hi = sec_idx_t'(n - 1);
        return r;
    endfunction

    function automatic logic is_single(region_t r);
        return r.lo == r.hi;
    endfunction

endpackage

// File: rtl/halving_iso_step.sv
// Next-region logic for one acknowledged halving verdict.
module halving_iso_step
    import halving_iso_pkg::*;
(
    input  region_t cur,
    input  logic    tested_fail,
    output region_t nxt,
    output logic    nxt_single
);
    sec_idx_t mid;

    always_comb begin
        mid = split_point(cur);
        nxt = cur;
        if (tested_fail) begin
            // The enabled lower half failed: it holds the fault.
            nxt.hi = mid;
        end else begin
            // The enabled half passed: the disabled half is now suspect.
            nxt.lo = mid + sec_idx_t'(1);
        end
        nxt_single = is_single(nxt);
    end
endmodule

// File: rtl/halving_iso_mask.sv
// Enable-mask generator: all sections for the whole test,
// the lower half of the region during halving, none otherwise.
module halving_iso_mask
    import halving_iso_pkg::*;
#(
    parameter int N_SEC = 16
) (
    input  phase_e           phase,
    input  region_t          region,
    output logic [N_SEC-1:0] mask
);
    sec_idx_t mid;
    logic     whole_on;
    logic     halve_on;

    assign mid      = split_point(region);
    assign whole_on = (phase == PH_WHOLE);
    assign halve_on = (phase == PH_HALVE);

    for (genvar k = 0; k < N_SEC; k++) begin : g_bit
        localparam sec_idx_t KI = sec_idx_t'(k);
        logic in_half;
        assign in_half = (KI >= region.lo) && (KI <= mid);
        assign mask[k] = whole_on | (halve_on & in_half);
    end
endmodule

// File: rtl/halving_iso_fsm.sv
// Phase sequencer: whole-unit test, halving steps, final report.
module halving_iso_fsm
    import halving_iso_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   ack,
    input  logic   fail,
    input  logic   nxt_single,
    output phase_e phase,
    output logic   clean,
    output logic   load_full,
    output logic   advance
);
    phase_e phase_q, phase_d;
    logic   clean_q, clean_d;
    logic   can_start;

    assign can_start = (phase_q == PH_IDLE) || (phase_q == PH_FINAL);
    assign load_full = can_start && start;
    assign advance   = (phase_q == PH_HALVE) && ack;

    always_comb begin
        phase_d = phase_q;
        clean_d = clean_q;
        unique case (phase_q)
            PH_IDLE, PH_FINAL: begin
                if (start) begin
                    phase_d = PH_WHOLE;
                    clean_d = 1'b0;
                end
            end
            PH_WHOLE: begin
                if (ack) begin
                    if (fail) begin
                        phase_d = PH_HALVE;
                    end else begin
                        phase_d = PH_FINAL;
                        clean_d = 1'b1;
                    end
                end
            end
            PH_HALVE: begin
                if (ack && nxt_single) begin
                    phase_d = PH_FINAL;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            clean_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            clean_q <= clean_d;
        end
    end

    assign phase = phase_q;
    assign clean = clean_q;
endmodule

// File: rtl/halving_isolator.sv
module halving_isolator
    import halving_iso_pkg::*;
#(
    parameter int N_SEC = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    output logic                     test_req,
    output logic [N_SEC-1:0]         test_mask,
    input  logic                     test_ack,
    input  logic                     test_fail,
    output logic                     busy,
    output logic                     done,
    output logic                     no_fault,
    output logic [$clog2(N_SEC)-1:0] fault_idx
);
    localparam int IDX_W = $clog2(N_SEC);

    phase_e  phase;
    logic    clean;
    logic    load_full;
    logic    advance;
    logic    nxt_single;
    region_t region_q;
    region_t region_nxt;

    halving_iso_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .ack        (test_ack),
        .fail       (test_fail),
        .nxt_single (nxt_single),
        .phase      (phase),
        .clean      (clean),
        .load_full  (load_full),
        .advance    (advance)
    );

    halving_iso_step u_step (
        .cur         (region_q),
        .tested_fail (test_fail),
        .nxt         (region_nxt),
        .nxt_single  (nxt_single)
    );

    always_ff @(posedge clk) begin
        if (rst || load_full) begin
            region_q <= full_region(N_SEC);
        end else if (advance) begin
            region_q <= region_nxt;
        end
    end

    halving_iso_mask #(.N_SEC(N_SEC)) u_mask (
        .phase  (phase),
        .region (region_q),
        .mask   (test_mask)
    );

    assign test_req  = (phase == PH_WHOLE) || (phase == PH_HALVE);
    assign busy      = test_req;
    assign done      = (phase == PH_FINAL);
    assign no_fault  = done && clean;
    assign fault_idx = done ? region_q.lo[IDX_W-1:0] : '0;
endmodule

// File: rtl/halving_isolator_chk.sv
module halving_isolator_chk #(
    parameter int N_SEC = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     start,
    input logic                     test_req,
    input logic [N_SEC-1:0]         test_mask,
    input logic                     test_ack,
    input logic                     test_fail,
    input logic                     busy,
    input logic                     done,
    input logic                     no_fault,
    input logic [$clog2(N_SEC)-1:0] fault_idx
);
    localparam int LOG2N = $clog2(N_SEC);

    logic [7:0] halve_acks;
    logic       whole_mask;

    assign whole_mask = &test_mask;

    always_ff @(posedge clk) begin
        if (rst || (start && !busy)) begin
            halve_acks <= '0;
        end else if (test_req && test_ack && !whole_mask) begin
            halve_acks <= halve_acks + 8'd1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!test_req && !done && !no_fault && test_mask == '0)); // R1

    AST_START_WHOLE: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (test_req && whole_mask)); // R2

    AST_CLEAN_IS_DONE: assert property (@(posedge clk) disable iff (rst)
        no_fault |-> (done && !test_req)); // R3

    AST_MASK_IDLE: assert property (@(posedge clk) disable iff (rst)
        !test_req |-> (test_mask == '0)); // R4

    AST_MASK_LIVE: assert property (@(posedge clk) disable iff (rst)
        test_req |-> (test_mask != '0)); // R4

    AST_REGION_HALVES: assert property (@(posedge clk) disable iff (rst)
        (test_req && test_ack && !whole_mask) |=>
            (!test_req || ($countones(test_mask) * 2 == $countones($past(test_mask))))); // R5

    AST_STEP_COUNT: assert property (@(posedge clk) disable iff (rst)
        ($rose(done) && !no_fault) |-> (int'(halve_acks) == LOG2N)); // R7

    AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !test_ack) |=> (busy && $stable(test_mask))); // R8

    AST_WAIT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (test_req && !test_ack) |=> (test_req && $stable(test_mask))); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(fault_idx) && $stable(no_fault))); // R10
endmodule

bind halving_isolator halving_isolator_chk #(.N_SEC(N_SEC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .test_req  (test_req),
    .test_mask (test_mask),
    .test_ack  (test_ack),
    .test_fail (test_fail),
    .busy      (busy),
    .done      (done),
    .no_fault  (no_fault),
    .fault_idx (fault_idx)
);

// File: tb/halving_isolator_bench.sv
module halving_isolator_bench;
    localparam int N  = 16;
    localparam int LG = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         test_ack = 1'b0;
    logic         test_fail = 1'b0;
    logic         test_req;
    logic [N-1:0] test_mask;
    logic         busy;
    logic         done;
    logic         no_fault;
    logic [LG-1:0] fault_idx;

    halving_isolator #(.N_SEC(N)) u_halving_isolator (
        .clk(clk), .rst(rst), .start(start),
        .test_req(test_req), .test_mask(test_mask),
        .test_ack(test_ack), .test_fail(test_fail),
        .busy(busy), .done(done), .no_fault(no_fault), .fault_idx(fault_idx)
    );

    always #10 clk = ~clk;

    int  total = 0;
    int  bad = 0;
    bit  live = 1'b0;
    bit  ended = 1'b0;

    task automatic chk(bit ok, string tag, longint act, longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    // Behavioural reference: 0 idle, 1 whole test, 2 halving, 3 finished.
    int m_ph, m_lo, m_hi, m_md;
    bit m_nf;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_lo = 0; m_hi = N - 1; m_nf = 0;
        end else begin
            case (m_ph)
                0, 3: if (start) begin
                    m_ph = 1; m_lo = 0; m_hi = N - 1; m_nf = 0;
                end
                1: if (test_ack) begin
                    if (test_fail) m_ph = 2;
                    else begin m_ph = 3; m_nf = 1; end
                end
                2: if (test_ack) begin
                    m_md = (m_lo + m_hi) / 2;
                    if (test_fail) m_hi = m_md;
                    else m_lo = m_md + 1;
                    if (m_lo == m_hi) m_ph = 3;
                end
                default: m_ph = 0;
            endcase
        end
    end

    function automatic logic [N-1:0] exp_mask(int ph, int lo, int hi);
        logic [N-1:0] m = '0;
        for (int k = 0; k < N; k++) begin
            if (ph == 1) m[k] = 1'b1;
            else if (ph == 2) m[k] = (k >= lo) && (k <= (lo + hi) / 2);
        end
        return m;
    endfunction

    // Per-cycle comparison, half a period after the edge.
    always @(negedge clk) begin
        if (live && !rst) begin
            chk(test_req == (m_ph == 1 || m_ph == 2), "R2 req", test_req, (m_ph == 1 || m_ph == 2));
            chk(busy == (m_ph == 1 || m_ph == 2), "R8 busy", busy, (m_ph == 1 || m_ph == 2));
            chk(test_mask == exp_mask(m_ph, m_lo, m_hi), "R4 mask", test_mask, exp_mask(m_ph, m_lo, m_hi));
            chk(done == (m_ph == 3), "R10 done", done, (m_ph == 3));
            chk(no_fault == (m_ph == 3 && m_nf), "R3 no_fault", no_fault, (m_ph == 3 && m_nf));
            if (m_ph == 3 && !m_nf)
                chk(fault_idx == m_lo[LG-1:0], "R7 idx", fault_idx, m_lo);
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // One isolation run against a simulated unit with an optional fault.
    task automatic run(int fault, bit has, int lat, bit poke, output int steps);
        bit whole;
        start = 1'b1;
        tick();
        start = 1'b0;
        steps = 0;
        for (int it = 0; it < 100 && !done; it++) begin
            if (test_req) begin
                for (int w = 0; w < lat; w++) begin
                    test_fail = ~test_fail;          // R9 noise without ack
                    if (poke && w == 0) start = 1'b1; // R8 start while busy
                    tick();
                    start = 1'b0;
                end
                whole = &test_mask;
                test_ack = 1'b1;
                test_fail = has && test_mask[fault];
                tick();
                test_ack = 1'b0;
                test_fail = 1'b0;
                if (!whole) steps++;
            end else begin
                tick();
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!ended) begin
            total++; bad++;
            $display("FAIL R7 watchdog expired act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int steps;
        int held;
        repeat (3) tick();
        @(negedge clk);
        chk(!test_req && !busy && !done && !no_fault && test_mask == '0, "R1 reset",
            {test_req, busy, done, no_fault}, 0);
        tick();
        rst = 1'b0;
        live = 1'b1;
        @(negedge clk);
        chk(!test_req && test_mask == '0, "R1 after reset", test_mask, 0);
        // R8: stray acknowledge while idle
        tick();
        test_ack = 1'b1; test_fail = 1'b1; tick(); test_ack = 1'b0; test_fail = 1'b0;
        chk(!busy && !done, "R8 idle ack", {busy, done}, 0);

        // Fault at every section, with varying latency.
        for (int f = 0; f < N; f++) begin
            run(f, 1'b1, f % 3, 1'b0, steps);
            chk(done && !no_fault, "R7 done", {done, no_fault}, 2);
            chk(steps == LG, "R7 steps", steps, LG);
            if (f < N / 2) chk(fault_idx == f, "R5 low-half fault", fault_idx, f);
            else           chk(fault_idx == f, "R6 high-half fault", fault_idx, f);
        end

        // No fault: early exit.
        run(0, 1'b0, 1, 1'b0, steps);
        chk(done && no_fault && fault_idx == 0, "R3 clean exit", {done, no_fault, fault_idx}, 6'h30);
        chk(steps == 0, "R3 no halving", steps, 0);

        // R10: result holds, stray acks ignored.
        held = fault_idx;
        for (int i = 0; i < 3; i++) begin
            test_ack = 1'b1; test_fail = i[0]; tick();
        end
        test_ack = 1'b0; test_fail = 1'b0;
        chk(done && no_fault && fault_idx == held, "R10 hold", fault_idx, held);

        // R8: start pulsed during a run; R10 restart after clean run.
        run(11, 1'b1, 2, 1'b1, steps);
        chk(fault_idx == 11 && !no_fault, "R10 restart", fault_idx, 11);
        chk(steps == LG, "R8 poke steps", steps, LG);
        run(2, 1'b1, 0, 1'b1, steps);
        chk(fault_idx == 2, "R9 fast ack", fault_idx, 2);

        // R2: start on a finished run re-issues the whole test.
        start = 1'b1; tick(); start = 1'b0;
        @(negedge clk);
        chk(test_req && test_mask == '1, "R2 whole", test_mask, 16'hffff);
        tick();
        test_ack = 1'b1; test_fail = 1'b0; tick(); test_ack = 1'b0;
        @(negedge clk);
        chk(done && no_fault, "R3 pass", {done, no_fault}, 3);
        tick();

        ended = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule